// File: doc/BRIEF.md
# Edge/Level Interrupt Event Filter

This block sits on the host side of an I/O expander's interrupt line and works out which lines have an event to report. Each time the expander is serviced, the host fetches two words over its bus: first the expander's interrupt-status word, then its input-port word. The fetch logic hands both to this block. The block keeps the last input level it saw for every line. It compares the new input word against those stored levels and applies a trigger mode chosen per line. It then merges in the status-word hits and returns one pending-event vector with a single-cycle valid pulse.

The two words cannot be read at the same instant, so either path alone can miss an event. A short pulse may rise and fall before the input read; it leaves no level change but does set a status bit. A line may change after the status read; it shows up only as a level change. Each line's event is therefore the OR of both paths, filtered by its mode.

Both inputs are strobe-qualified with no ready: the block accepts a word in every cycle its valid is high, so the fetch logic never stalls. The pending output also has no back-pressure. The consumer must take the vector in the cycle its valid is high, because the vector reads zero in every other cycle.

Top module: `evt_irq_filter`

## Requirements
- R1: A line in mode code 0 (rising) reports an event when its stored level is 0 and its snapshot level is 1.
- R2: A line in mode code 1 (falling) reports an event when its stored level is 1 and its snapshot level is 0.
- R3: A line in mode code 2 (both edges) reports an event whenever its snapshot level differs from its stored level.
- R4: A line in mode code 3 reports an event whenever its snapshot level is 1, and a line in mode code 4 reports an event whenever it is 0, whatever the stored level.
- R5: A line whose mode code is 5, 6 or 7 never reports an event, even with a status hit or a level change.
- R6: An enabled line in modes 0 to 4 with its status bit set and no level change reports an event.
- R7: On a line in mode 0 or 1, a status hit that comes with a level change in the opposite direction reports no event.
- R8: The status words given since the previous input snapshot are ORed together. A status word given in the same cycle as the input snapshot is included. The gathered status is cleared once each input snapshot has been taken.
- R9: A line whose enable bit (bit i of `cfg_en` for line i) is 0 never reports an event, yet its stored level still follows every snapshot.
- R10: The first input snapshot after reset reports no events and only loads the stored levels.
- R11: `pend_valid` is high for exactly the one cycle after each cycle with `in_valid` high, and `pend_vec` is all zeros whenever `pend_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | NLINES | Per-line event enable |
| cfg_mode | input | 3*NLINES | Per-line trigger mode code; line i occupies bits [3i+2:3i] |
| sts_valid | input | 1 | Status snapshot strobe |
| sts_word | input | NLINES | Interrupt-status snapshot, one bit per line |
| in_valid | input | 1 | Input snapshot strobe; triggers an evaluation |
| in_word | input | NLINES | Input-port snapshot, one bit per line |
| pend_valid | output | 1 | One-cycle pulse carrying the result of an evaluation |
| pend_vec | output | NLINES | Pending events, one bit per line |

## Verification
Every internal register shows up at the ports at the very next `pend_valid` pulse. A stored level that is stale or not loaded gives a wrong edge decision on the next snapshot of that line. The bench tests this by updating the stored levels on disabled lines and then re-enabling them. Status bits that leak, or that are not cleared, add or drop bits one snapshot later. Status strobes are therefore spread over several cycles and followed by a snapshot with no status. A missing or extra pipeline stage moves the valid pulse by one cycle, and that is checked on every evaluation.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_BOTH = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_mode_e;

  // Decision for one line: observed edge/level match merged with a status
  // hit that left no visible level change behind.
  function automatic logic line_event(input logic [MODE_W-1:0] mode,
                                      input logic prev_lvl,
                                      input logic cur_lvl,
                                      input logic sts_hit);
    logic rise;
    logic fall;
    logic chg;
    logic hidden;
    logic res;
    rise   = !prev_lvl && cur_lvl;
    fall   = prev_lvl && !cur_lvl;
    chg    = prev_lvl ^ cur_lvl;
    hidden = sts_hit && !chg;
    case (mode)
      TRIG_RISE: res = rise | hidden;
      TRIG_FALL: res = fall | hidden;
      TRIG_BOTH: res = chg | hidden;
      TRIG_HIGH: res = cur_lvl | hidden;
      TRIG_LOW:  res = !cur_lvl | hidden;
      default:   res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/evt_status_hold.sv
module evt_status_hold #(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_valid,
  input  logic [NLINES-1:0] sts_word,
  input  logic              consume,
  output logic [NLINES-1:0] sts_eff
);

  logic [NLINES-1:0] sts_q;
  logic [NLINES-1:0] sts_new;

  assign sts_new = sts_valid ? sts_word : '0;
  assign sts_eff = sts_q | sts_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (consume) begin
      sts_q <= '0;
    end else if (sts_valid) begin
      sts_q <= sts_q | sts_word;
    end
  end

  // R8: gathered status never survives an input snapshot
  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (sts_q == '0));

  // R8: strobed status bits are kept until consumed
  p_status_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !consume) |=> ((sts_q & $past(sts_word)) == $past(sts_word)));

endmodule

// File: rtl/evt_prev_track.sv
module evt_prev_track #(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NLINES-1:0] in_word,
  output logic [NLINES-1:0] prev_lvl,
  output logic              primed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      primed   <= 1'b0;
    end else if (in_valid) begin
      prev_lvl <= in_word;
      primed   <= 1'b1;
    end
  end

  // R9: stored levels follow every snapshot, enabled or not
  p_prev_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (prev_lvl == $past(in_word)));

  // R10: priming only happens through a snapshot
  p_primed_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> $past(in_valid));

endmodule

// File: rtl/evt_line_decode.sv
module evt_line_decode
  import evt_filter_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic [NLINES-1:0]        cfg_en,
  input  logic [MODE_W*NLINES-1:0] cfg_mode,
  input  logic [NLINES-1:0]        prev_lvl,
  input  logic [NLINES-1:0]        cur_lvl,
  input  logic [NLINES-1:0]        sts_hit,
  output logic [NLINES-1:0]        line_evt
);

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    logic [MODE_W-1:0] mode_i;
    assign mode_i = cfg_mode[gi*MODE_W +: MODE_W];
    assign line_evt[gi] = cfg_en[gi] &&
                          line_event(mode_i, prev_lvl[gi], cur_lvl[gi], sts_hit[gi]);
  end

endmodule

// File: rtl/evt_irq_filter.sv
module evt_irq_filter
  import evt_filter_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        cfg_en,
  input  logic [MODE_W*NLINES-1:0] cfg_mode,
  input  logic                     sts_valid,
  input  logic [NLINES-1:0]        sts_word,
  input  logic                     in_valid,
  input  logic [NLINES-1:0]        in_word,
  output logic                     pend_valid,
  output logic [NLINES-1:0]        pend_vec
);

  logic [NLINES-1:0] sts_eff;
  logic [NLINES-1:0] prev_lvl;
  logic              primed;
  logic [NLINES-1:0] line_evt;
  logic [NLINES-1:0] evt_gated;

  evt_status_hold #(.NLINES(NLINES)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_valid (sts_valid),
    .sts_word  (sts_word),
    .consume   (in_valid),
    .sts_eff   (sts_eff)
  );

  evt_prev_track #(.NLINES(NLINES)) u_prev (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .prev_lvl (prev_lvl),
    .primed   (primed)
  );

  evt_line_decode #(.NLINES(NLINES)) u_dec (
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .prev_lvl (prev_lvl),
    .cur_lvl  (in_word),
    .sts_hit  (sts_eff),
    .line_evt (line_evt)
  );

  assign evt_gated = primed ? line_evt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_vec   <= '0;
    end else begin
      pend_valid <= in_valid;
      pend_vec   <= in_valid ? evt_gated : '0;
    end
  end

  // R11: one result pulse per snapshot, exactly one cycle later
  p_pend_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pend_valid);
  p_pend_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> $past(in_valid));
  p_vec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (pend_vec == '0));

  // R9: disabled lines stay silent
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((pend_vec & ~$past(cfg_en)) == '0));

  // R10: first snapshot after reset yields nothing
  p_first_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed) |=> (pend_vec == '0));

endmodule

// File: tb/evt_irq_filter_test.sv
module evt_irq_filter_test;

  localparam int unsigned NL = 8;
  localparam time CLK_PERIOD = 10ns;
  // line modes: L0 rise, L1 fall, L2 both, L3 high, L4 low, L5 rise, L6 code 5, L7 both
  localparam logic [3*NL-1:0] MODES = 24'h544688;
  localparam int unsigned NVEC = 9;
  // {sts, in, en, expected}
  localparam logic [31:0] TBL [0:NVEC-1] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00},
    {8'h00, 8'h0F, 8'hFF, 8'h1D},
    {8'h00, 8'hF0, 8'hFF, 8'hA6},
    {8'hFF, 8'hF0, 8'hFF, 8'hBF},
    {8'h01, 8'hF1, 8'hFF, 8'h01},
    {8'h01, 8'hF0, 8'hFF, 8'h00},
    {8'hFF, 8'h0F, 8'h00, 8'h00},
    {8'h00, 8'h0F, 8'hFF, 8'h18},
    {8'h00, 8'hF0, 8'h0F, 8'h06}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] cfg_en = '0;
  logic [3*NL-1:0] cfg_mode = MODES;
  logic sts_valid = 1'b0;
  logic [NL-1:0] sts_word = '0;
  logic in_valid = 1'b0;
  logic [NL-1:0] in_word = '0;
  logic pend_valid;
  logic [NL-1:0] pend_vec;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_filter #(.NLINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .sts_valid(sts_valid), .sts_word(sts_word), .in_valid(in_valid),
    .in_word(in_word), .pend_valid(pend_valid), .pend_vec(pend_vec)
  );

  function automatic string vec_tag(int idx);
    case (idx)
      0: return "R10 first snapshot";
      1: return "R1/R3/R4 rise edges";
      2: return "R2/R3/R4 fall edges";
      3: return "R6/R5 status merge";
      4: return "R1 rise with status";
      5: return "R7 opposite edge";
      6: return "R9 all disabled";
      7: return "R9 tracked while disabled";
      default: return "R9 partial enable";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Optional status strobe, then input strobe; result checked one cycle later
  // and idle checked the cycle after that.
  task automatic snap(logic [NL-1:0] sts, logic [NL-1:0] inw, logic [NL-1:0] en,
                      logic [NL-1:0] exp, string tag);
    cfg_en = en;
    if (sts != '0) begin
      sts_valid = 1'b1; sts_word = sts;
      @(negedge clk);
      sts_valid = 1'b0; sts_word = '0;
    end
    in_valid = 1'b1; in_word = inw;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R11 valid"}, 32'(pend_valid), 32'd1);
    check(tag, 32'(pend_vec), 32'(exp));
    @(negedge clk);
    check({tag, " R11 idle"}, {31'd0, pend_valid} | 32'(pend_vec), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {31'd0, pend_valid} | 32'(pend_vec), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      snap(TBL[i][31:24], TBL[i][23:16], TBL[i][15:8], TBL[i][7:0], vec_tag(i));
    end

    // R8: two status strobes on separate cycles gather; stored level F0
    cfg_en = 8'hFF;
    sts_valid = 1'b1; sts_word = 8'h01; @(negedge clk);
    sts_word = 8'h02; @(negedge clk);
    sts_valid = 1'b0; sts_word = '0; @(negedge clk);
    snap(8'h00, 8'hF0, 8'hFF, 8'h03, "R8 gathered status");
    // R8: gathered status cleared after the snapshot
    snap(8'h00, 8'hF0, 8'hFF, 8'h00, "R8 status cleared");
    // R8: status in same cycle as input snapshot
    sts_valid = 1'b1; sts_word = 8'h80; in_valid = 1'b1; in_word = 8'hF0;
    @(negedge clk);
    sts_valid = 1'b0; sts_word = '0; in_valid = 1'b0;
    check("R8 same-cycle status", {23'd0, pend_valid, pend_vec}, {23'd0, 1'b1, 8'h80});
    @(negedge clk);
    // R5: only a code-5 line with status hit and level change
    snap(8'h40, 8'hB0, 8'h40, 8'h00, "R5 unused mode silent");

    // R10: reset re-arms the first-snapshot rule
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset state again", {31'd0, pend_valid} | 32'(pend_vec), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    snap(8'hFF, 8'h0F, 8'hFF, 8'h00, "R10 first after reset");
    snap(8'h00, 8'hF0, 8'hFF, 8'hA6, "R10 armed after first");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule